// File: doc/BRIEF.md
# Look-ahead First-Order Recursive Filter

This block is a single-pole recursive filter. It runs at the sample clock and takes one signed 16-bit sample and produces one filtered sample on every clock. The target response is y[n] = b1·y[n-1] + x[n]. The coefficient b1 is an 18-bit signed value with 16 fractional bits, so it covers [-2, 2).

No multiplier result may reach an adder in the cycle it is formed. A plain register in the feedback path would turn the loop into y[n] = b1·y[n-2] + x[n], which is wrong. The block therefore uses look-ahead on the recursion: y[n] = b1²·y[n-2] + b1·x[n-1] + x[n].

- The b1² term closes a loop of two registers: the output register and the product register.
- The b1·x[n-1] term is an ordinary pipelined feed-forward product.
- The x[n] term passes through one extra register so that it lines up with the registered products.

b1² is worked out once, when the coefficient is loaded. Between samples, when the valid strobe is low, every piece of state holds, so the recursion carries on across gaps in the stream.

Top module: `lookahead_iir1`

## Requirements
- R1: A sample accepted at a rising edge (in_valid high) shows on y_out, with out_valid high, after the next rising edge: two cycles from the cycle it was presented. out_valid is high only in those cycles. A sample may be accepted on every clock.
- R2: With A = c2·y[n-2] + c1·x[n-1] + x[n]·2^16 computed at full precision, each output is y[n] = sat(floor((A + 2^15) / 2^16)). Here y and x count accepted samples only, c1 is the loaded coefficient, and c2 is its derived square.
- R3: On a load, c2 = min(131071, floor((b1·b1 + 2^15) / 2^16)). The value is always non-negative, and it saturates to 131071 when b1 = -131072.
- R4: Synchronous active-high reset clears out_valid, y_out, c1, c2 and all history. The first samples after reset therefore see y[-1] = y[-2] = x[-1] = 0.
- R5: While in_valid is low, no state advances and y_out holds its last value. A stream with gaps gives the same sequence of outputs as the same samples sent back to back.
- R6: Results are clipped to the 16-bit signed range [-32768, 32767]. Clipped values are the ones fed back.
- R7: A coef_load pulse stores coef_in as c1 at that edge and c2 one edge later. Samples accepted two or more edges after the pulse use both new values. The pulse leaves y and x history untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| coef_load | input | 1 | Load strobe for the coefficient |
| coef_in | input | 18 | Signed coefficient b1, 16 fractional bits |
| in_valid | input | 1 | Sample present on x_in |
| x_in | input | 16 | Signed input sample |
| out_valid | output | 1 | y_out carries a new result |
| y_out | output | 16 | Signed filtered sample |

## Verification
Some properties are checked on every cycle:
- the two-cycle alignment between in_valid and out_valid;
- y_out holding steady while no result is produced;
- the cleared state right after reset;
- c1 taking the loaded value;
- c2 never going negative.

The arithmetic itself can only be shown by the bench scenarios. These compare every output against an independent model of the look-ahead equation, under:
- contiguous and gapped streams;
- saturating inputs;
- the extreme negative coefficient;
- a coefficient change with history in flight;
- a reset in the middle of a stream.

// File: rtl/iirla_pkg.sv
package iirla_pkg;
  localparam int SAMPLE_W = 16;
  localparam int COEF_W   = 18;
  localparam int FRAC_W   = 16;

  typedef enum logic {
    SQ_IDLE,
    SQ_ROUND
  } sq_state_t;
endpackage

// File: rtl/iirla_coef.sv
module iirla_coef
  import iirla_pkg::*;
#(
  parameter int CW   = COEF_W,
  parameter int FRAC = FRAC_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic signed [CW-1:0] coef_in,
  output logic signed [CW-1:0] c1,
  output logic signed [CW-1:0] c2
);
  localparam int SW = 2 * CW;
  localparam logic signed [SW-1:0] HALF = SW'(1) <<< (FRAC - 1);
  localparam logic signed [SW-1:0] CMAX = {{(CW + 1){1'b0}}, {(CW - 1){1'b1}}};

  logic signed [SW-1:0] sq_q;
  logic signed [SW-1:0] sq_rnd;
  logic signed [SW-1:0] sq_sh;
  logic signed [CW-1:0] c2_next;
  logic signed [CW-1:0] c1_q;
  logic signed [CW-1:0] c2_q;
  sq_state_t            st_q;

  // rounding of the registered square: product never meets adder in one cycle
  always_comb begin
    sq_rnd = sq_q + HALF;
    sq_sh  = sq_rnd >>> FRAC;
    if (sq_sh > CMAX) c2_next = CMAX[CW-1:0];
    else              c2_next = sq_sh[CW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      c1_q <= '0;
      c2_q <= '0;
      sq_q <= '0;
      st_q <= SQ_IDLE;
    end else begin
      if (load) begin
        c1_q <= coef_in;
        sq_q <= SW'(coef_in) * SW'(coef_in);
        st_q <= SQ_ROUND;
      end else begin
        st_q <= SQ_IDLE;
      end
      if (st_q == SQ_ROUND) c2_q <= c2_next;
    end
  end

  assign c1 = c1_q;
  assign c2 = c2_q;
endmodule

// File: rtl/iirla_fwd.sv
module iirla_fwd
  import iirla_pkg::*;
#(
  parameter int DW = SAMPLE_W,
  parameter int CW = COEF_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    accept,
  input  logic signed [DW-1:0]    x_in,
  input  logic signed [CW-1:0]    c1,
  output logic signed [DW-1:0]    x_d,
  output logic signed [DW+CW-1:0] ff_prod,
  output logic                    stg_v
);
  localparam int PW = DW + CW;

  logic signed [DW-1:0] x_q;
  logic signed [PW-1:0] m_q;
  logic                 v_q;

  // x_q holds the last accepted sample: x[n] for stage two, x[n-1] for the product
  always_ff @(posedge clk) begin
    if (rst) begin
      x_q <= '0;
      m_q <= '0;
      v_q <= 1'b0;
    end else begin
      v_q <= accept;
      if (accept) begin
        x_q <= x_in;
        m_q <= PW'(c1) * PW'(x_q);
      end
    end
  end

  assign x_d     = x_q;
  assign ff_prod = m_q;
  assign stg_v   = v_q;
endmodule

// File: rtl/iirla_loop.sv
module iirla_loop
  import iirla_pkg::*;
#(
  parameter int DW   = SAMPLE_W,
  parameter int CW   = COEF_W,
  parameter int FRAC = FRAC_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    accept,
  input  logic                    stg_v,
  input  logic signed [DW-1:0]    x_d,
  input  logic signed [DW+CW-1:0] ff_prod,
  input  logic signed [CW-1:0]    c2,
  output logic                    out_valid,
  output logic signed [DW-1:0]    y_out
);
  localparam int PW = DW + CW;
  localparam int AW = PW + 2;
  localparam logic signed [AW-1:0] HALF = AW'(1) <<< (FRAC - 1);
  localparam logic signed [AW-1:0] YMAX = {{(AW - DW + 1){1'b0}}, {(DW - 1){1'b1}}};
  localparam logic signed [AW-1:0] YMIN = {{(AW - DW + 1){1'b1}}, {(DW - 1){1'b0}}};

  logic signed [PW-1:0] q_q;
  logic signed [DW-1:0] y_q;
  logic signed [DW-1:0] yp_q;
  logic                 ov_q;
  logic signed [DW-1:0] y_sel;
  logic signed [AW-1:0] acc;
  logic signed [AW-1:0] acc_sh;
  logic signed [DW-1:0] y_next;

  // y[n-2] for the sample now entering: if the previous sample is still in
  // stage two, y_q is y[n-2]; otherwise y_q already holds y[n-1]
  always_comb y_sel = stg_v ? y_q : yp_q;

  always_comb begin
    acc    = AW'(q_q) + AW'(ff_prod) + (AW'(x_d) <<< FRAC) + HALF;
    acc_sh = acc >>> FRAC;
    if (acc_sh > YMAX)      y_next = YMAX[DW-1:0];
    else if (acc_sh < YMIN) y_next = YMIN[DW-1:0];
    else                    y_next = acc_sh[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_q  <= '0;
      y_q  <= '0;
      yp_q <= '0;
      ov_q <= 1'b0;
    end else begin
      if (accept) q_q <= PW'(c2) * PW'(y_sel);
      ov_q <= stg_v;
      if (stg_v) begin
        y_q  <= y_next;
        yp_q <= y_q;
      end
    end
  end

  assign out_valid = ov_q;
  assign y_out     = y_q;
endmodule

// File: rtl/lookahead_iir1.sv
module lookahead_iir1
  import iirla_pkg::*;
#(
  parameter int DW   = SAMPLE_W,
  parameter int CW   = COEF_W,
  parameter int FRAC = FRAC_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 coef_load,
  input  logic signed [CW-1:0] coef_in,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] x_in,
  output logic                 out_valid,
  output logic signed [DW-1:0] y_out
);
  localparam int PW = DW + CW;

  logic signed [CW-1:0] c1_w;
  logic signed [CW-1:0] c2_w;
  logic signed [DW-1:0] x_d_w;
  logic signed [PW-1:0] ff_w;
  logic                 stg_v_w;

  iirla_coef #(.CW(CW), .FRAC(FRAC)) u_coef (
    .clk(clk), .rst(rst), .load(coef_load), .coef_in(coef_in),
    .c1(c1_w), .c2(c2_w)
  );

  iirla_fwd #(.DW(DW), .CW(CW)) u_fwd (
    .clk(clk), .rst(rst), .accept(in_valid), .x_in(x_in), .c1(c1_w),
    .x_d(x_d_w), .ff_prod(ff_w), .stg_v(stg_v_w)
  );

  iirla_loop #(.DW(DW), .CW(CW), .FRAC(FRAC)) u_loop (
    .clk(clk), .rst(rst), .accept(in_valid), .stg_v(stg_v_w), .x_d(x_d_w),
    .ff_prod(ff_w), .c2(c2_w), .out_valid(out_valid), .y_out(y_out)
  );
endmodule

// File: rtl/lookahead_iir1_chk.sv
module lookahead_iir1_chk #(
  parameter int DW = 16,
  parameter int CW = 18
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 coef_load,
  input logic signed [CW-1:0] coef_in,
  input logic                 in_valid,
  input logic                 out_valid,
  input logic signed [DW-1:0] y_out,
  input logic signed [CW-1:0] c1_w,
  input logic signed [CW-1:0] c2_w
);
  // R1: result strobe trails acceptance by exactly two edges
  p_latency_r1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> (out_valid == $past(in_valid, 2)));

  // R5: output never moves without a new result
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !out_valid) |-> $stable(y_out));

  // R4: state right after reset
  p_reset_r4: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && y_out == '0));

  // R7: c1 takes the loaded value at the load edge
  p_load_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(coef_load)) |-> (c1_w == $past(coef_in)));

  // R3: the derived square is never negative
  p_sq_nonneg_r3: assert property (@(posedge clk) disable iff (rst)
    c2_w >= 0);
endmodule

bind lookahead_iir1 lookahead_iir1_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .coef_load(coef_load), .coef_in(coef_in),
  .in_valid(in_valid), .out_valid(out_valid), .y_out(y_out),
  .c1_w(c1_w), .c2_w(c2_w)
);

// File: tb/lookahead_iir1_tb.sv
`timescale 1ns/1ps
module lookahead_iir1_tb;
  localparam int DW = 16;
  localparam int CW = 18;
  localparam int CLK_P = 4;
  localparam int NV = 8;
  // b1 = 0.5 (c2 = 0.25), hand-worked look-ahead results
  localparam int TV_X [NV] = '{1000, 0, 0, 0, 2000, -4000, 0, 0};
  localparam int TV_Y [NV] = '{1000, 500, 250, 125, 2063, -2969, -1484, -742};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic coef_load = 1'b0;
  logic signed [CW-1:0] coef_in = '0;
  logic in_valid = 1'b0;
  logic signed [DW-1:0] x_in = '0;
  logic out_valid;
  logic signed [DW-1:0] y_out;

  int total = 0;
  int bad = 0;
  string tag = "R4";

  int mc1 = 0, mc2 = 0, ya = 0, yb = 0, mx1 = 0;
  bit pv1 = 0, pv2 = 0;
  int pe1 = 0, pe2 = 0, held = 0;

  always #(CLK_P / 2) clk = ~clk;

  lookahead_iir1 u_dut (
    .clk(clk), .rst(rst), .coef_load(coef_load), .coef_in(coef_in),
    .in_valid(in_valid), .x_in(x_in), .out_valid(out_valid), .y_out(y_out)
  );

  function automatic int sq_coef(int b);
    longint r = (longint'(b) * longint'(b) + 32768) >>> 16;
    if (r > 131071) r = 131071;
    return int'(r);
  endfunction

  function automatic int sat16(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  task automatic check(bit ok, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic cycle(bit v, int x, bit ld, int b, bit use_f, int fexp);
    int yn;
    longint acc;
    @(negedge clk);
    check(out_valid == pv2, "out_valid", longint'(out_valid), longint'(pv2));
    if (pv2) begin
      check(y_out == pe2, "y_out", y_out, pe2);
      held = pe2;
    end else begin
      check(y_out == held, "y_out held", y_out, held);
    end
    pv2 = pv1;
    pe2 = pe1;
    pv1 = v;
    if (v) begin
      acc = longint'(mc2) * yb + longint'(mc1) * mx1 + (longint'(x) <<< 16);
      yn = sat16((acc + 32768) >>> 16);
      yb = ya;
      ya = yn;
      mx1 = x;
      pe1 = use_f ? fexp : yn;
    end
    if (ld) begin
      mc1 = b;
      mc2 = sq_coef(b);
    end
    in_valid = v;
    x_in = DW'(x);
    coef_load = ld;
    coef_in = CW'(b);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cycle(0, 0, 0, 0, 0, 0);
  endtask

  task automatic load(int b);
    cycle(0, 0, 1, b, 0, 0);
    idle(2);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    coef_load = 1'b0;
    repeat (3) @(negedge clk);
    tag = "R4";
    check(out_valid == 1'b0, "reset out_valid", longint'(out_valid), 0);
    check(y_out == 0, "reset y_out", y_out, 0);
    mc1 = 0; mc2 = 0; ya = 0; yb = 0; mx1 = 0;
    pv1 = 0; pv2 = 0; pe1 = 0; pe2 = 0; held = 0;
    rst = 1'b0;
  endtask

  task automatic rand_run(int n, int pct_valid);
    for (int i = 0; i < n; i++) begin
      bit v = ($urandom_range(99) < pct_valid);
      int x = int'($urandom_range(65535)) - 32768;
      cycle(v, x, 0, 0, 0, 0);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();

    // R2: hand-worked vectors, back to back
    tag = "R2";
    load(32768);
    for (int i = 0; i < NV; i++) cycle(1, TV_X[i], 0, 0, 1, TV_Y[i]);
    idle(3);

    // R1: full-rate stream, one result per clock at two-cycle latency
    tag = "R1";
    load(int'($urandom_range(110000)) - 55000);
    rand_run(300, 100);
    idle(3);

    // R5: gapped stream must continue the recursion exactly
    tag = "R5";
    rand_run(400, 45);
    idle(3);

    // R7: coefficient change with history in place
    tag = "R7";
    load(-40000);
    rand_run(200, 70);
    idle(3);

    // R6: clipping at both rails, clipped values fed back
    tag = "R6";
    load(65536);
    for (int i = 0; i < 6; i++) cycle(1, 30000, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) cycle(1, -30000, 0, 0, 0, 0);
    idle(3);
    check(y_out == -32768, "negative rail", y_out, -32768);

    // R3: b1 = -2.0, square saturates to 131071
    do_reset();
    tag = "R3";
    load(-131072);
    cycle(1, 100, 0, 0, 1, 100);
    cycle(1, 0, 0, 0, 1, -200);
    cycle(1, 0, 0, 0, 1, 200);
    idle(3);

    // R4: reset in mid-stream clears history and coefficients
    tag = "R4";
    load(20000);
    rand_run(40, 80);
    do_reset();
    tag = "R4";
    load(32768);
    cycle(1, 500, 0, 0, 1, 500);
    cycle(1, 0, 0, 0, 1, 250);
    idle(3);

    // R2: random coefficients over mixed streams
    tag = "R2";
    for (int k = 0; k < 12; k++) begin
      load(int'($urandom_range(262143)) - 131072);
      rand_run(120, 60 + k * 3);
    end
    idle(4);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule